// File: doc/BRIEF.md
# Key-bit scalar ladder sequencer

This block drives a scalar point multiplication on a binary elliptic curve in projective coordinates. The field arithmetic lives elsewhere. The block holds the working coordinates, walks the scalar from bit 1 up to the top bit, and hands each group operation to an external step datapath through a start/done handshake.

On a start command it captures the scalar, the base x-coordinate and the curve constant, and sets up its working points. The initial accumulator depends on the lowest scalar bit. A correction point is prepared with two field squarings and one XOR. Each scalar bit always costs one doubling. Only bits that are one add an addition, which follows that bit's doubling. A single adjustment addition with the correction point ends the run. After it, a one-cycle completion pulse is raised and the projective coordinates are left on the outputs.

The datapath receives the operation code and the operand coordinates. It answers with one result pair and a one-cycle done. The sequencer writes the pair back to the coordinates that the operation updates.

Top module: `ecc_ladder_seq`

## Requirements
- R1: On an accepted start, the coordinate pair B is set to (x = xp_i, z = 1). The first request of the run is a doubling that presents this pair on the B operand ports.
- R2: The correction pair is computed at start as x = xp_i^4 XOR b_i and z = xp_i^2, squaring modulo the field polynomial (default x^163 + x^7 + x^6 + x^3 + 1). It is presented on the A operand ports of the adjustment request.
- R3: At start, the accumulator pair A is (xp_i, 1) when key_i[0] is 1 and (0, 0) when it is 0. It is seen on the A operand ports of the first addition.
- R4: Each run issues exactly FW-1 doubling requests, one for each scalar index 1 to FW-1 in ascending order. A doubling result replaces pair B.
- R5: An addition request (operands A and the freshly doubled B) follows the doubling of index i exactly when key bit i is 1. Its result replaces pair A, and no addition is issued for a zero bit.
- R6: After the last index, exactly one adjustment request is issued, with the correction pair in place of A. Its result replaces pair A.
- R7: Each request is a single-cycle dp_start_o with dp_op_o equal to 0 for doubling, 1 for addition and 2 for adjustment. No further request is made until dp_done_i has been seen.
- R8: A start that arrives while a run is in progress has no effect on that run or on its results.
- R9: done_o is high for exactly one cycle, the cycle after the adjustment's dp_done_i is taken. The four result ports then hold their values until the next accepted start.
- R10: During and after reset, done_o and dp_start_o are low and all four result ports are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a run (taken only when idle) |
| key_i | input | FW | Scalar |
| xp_i | input | FW | Base point x-coordinate |
| b_i | input | FW | Curve constant |
| dp_start_o | output | 1 | One-cycle request to the step datapath |
| dp_op_o | output | 2 | Request code: 0 double, 1 add, 2 adjust |
| dp_xp_o | output | FW | Captured base x-coordinate |
| dp_xa_o | output | FW | Operand A x (accumulator, or correction on adjust) |
| dp_za_o | output | FW | Operand A z |
| dp_xb_o | output | FW | Operand B x |
| dp_zb_o | output | FW | Operand B z |
| dp_done_i | input | 1 | Datapath finished the request |
| dp_rx_i | input | FW | Result x |
| dp_rz_i | input | FW | Result z |
| done_o | output | 1 | Run complete pulse |
| x1_o | output | FW | Final accumulator x |
| z1_o | output | FW | Final accumulator z |
| x2_o | output | FW | Final doubled-point x |
| z2_o | output | FW | Final doubled-point z |

## Verification
A start taken at one rising edge puts the first request on dp_start_o during the following cycle. Each later request comes out in the cycle after the edge that takes the previous dp_done_i, and done_o rises at the edge that takes the adjustment's done. The bench's datapath model and all the checks sample one time unit after the falling edge. The model answers a set number of falling edges after it sees a request. The bench therefore expects done_o exactly one model cycle after the adjustment answer, and it compares the final coordinates with its own replay of the run's operation order.

// File: rtl/ecc_seq_pkg.sv
package ecc_seq_pkg;

    localparam int unsigned DEF_FW = 163;
    localparam logic [DEF_FW-1:0] DEF_POLY = DEF_FW'('hC9);

    typedef enum logic [1:0] {
        OP_DOUBLE = 2'd0,
        OP_ADD    = 2'd1,
        OP_ADJUST = 2'd2
    } step_op_e;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_REQ  = 2'd1,
        ST_WAIT = 2'd2
    } seq_state_e;

endpackage

// File: rtl/gf_square.sv
module gf_square #(
    parameter int unsigned FW = 163,
    parameter logic [FW-1:0] POLY = FW'('hC9)
) (
    input  logic [FW-1:0] a,
    output logic [FW-1:0] y
);
    localparam int unsigned SW = 2 * FW - 1;

    logic [SW-1:0] spread;

    always_comb begin
        spread = '0;
        for (int i = 0; i < int'(FW); i++) begin
            spread[2*i] = a[i];
        end
        for (int j = int'(SW) - 1; j >= int'(FW); j--) begin
            if (spread[j]) begin
                spread[j] = 1'b0;
                spread[j-int'(FW) +: FW] = spread[j-int'(FW) +: FW] ^ POLY;
            end
        end
        y = spread[FW-1:0];
    end
endmodule

// File: rtl/key_walker.sv
module key_walker #(
    parameter int unsigned FW = 163
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          load,
    input  logic          advance,
    input  logic [FW-1:0] key,
    output logic          bit_now,
    output logic          last
);
    localparam int unsigned IW = $clog2(FW);

    logic [FW-1:0] key_q;
    logic [IW-1:0] idx_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            key_q <= '0;
            idx_q <= IW'(1);
        end else if (load) begin
            key_q <= key;
            idx_q <= IW'(1);
        end else if (advance) begin
            idx_q <= idx_q + IW'(1);
        end
    end

    assign bit_now = key_q[idx_q];
    assign last    = (idx_q == IW'(FW - 1));
endmodule

// File: rtl/ladder_fsm.sv
module ladder_fsm
    import ecc_seq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     start,
    input  logic     dp_done,
    input  logic     bit_now,
    input  logic     last,
    output logic     busy,
    output logic     dp_start,
    output step_op_e op,
    output logic     load,
    output logic     advance,
    output logic     capture,
    output logic     done
);
    seq_state_e state_q, state_d;
    step_op_e   op_q, op_d;
    logic       done_d;

    always_comb begin
        state_d = state_q;
        op_d    = op_q;
        load    = 1'b0;
        advance = 1'b0;
        capture = 1'b0;
        done_d  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    load    = 1'b1;
                    op_d    = OP_DOUBLE;
                    state_d = ST_REQ;
                end
            end
            ST_REQ: state_d = ST_WAIT;
            ST_WAIT: begin
                if (dp_done) begin
                    capture = 1'b1;
                    state_d = ST_REQ;
                    if (op_q == OP_DOUBLE && bit_now) begin
                        op_d = OP_ADD;
                    end else if (op_q == OP_ADJUST) begin
                        done_d  = 1'b1;
                        state_d = ST_IDLE;
                    end else if (last) begin
                        op_d = OP_ADJUST;
                    end else begin
                        advance = 1'b1;
                        op_d    = OP_DOUBLE;
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            op_q    <= OP_DOUBLE;
            done    <= 1'b0;
        end else begin
            state_q <= state_d;
            op_q    <= op_d;
            done    <= done_d;
        end
    end

    assign busy     = (state_q != ST_IDLE);
    assign dp_start = (state_q == ST_REQ);
    assign op       = op_q;
endmodule

// File: rtl/ecc_ladder_seq.sv
module ecc_ladder_seq
    import ecc_seq_pkg::*;
#(
    parameter int unsigned FW = DEF_FW,
    parameter logic [FW-1:0] POLY = FW'('hC9)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          start_i,
    input  logic [FW-1:0] key_i,
    input  logic [FW-1:0] xp_i,
    input  logic [FW-1:0] b_i,
    output logic          dp_start_o,
    output logic [1:0]    dp_op_o,
    output logic [FW-1:0] dp_xp_o,
    output logic [FW-1:0] dp_xa_o,
    output logic [FW-1:0] dp_za_o,
    output logic [FW-1:0] dp_xb_o,
    output logic [FW-1:0] dp_zb_o,
    input  logic          dp_done_i,
    input  logic [FW-1:0] dp_rx_i,
    input  logic [FW-1:0] dp_rz_i,
    output logic          done_o,
    output logic [FW-1:0] x1_o,
    output logic [FW-1:0] z1_o,
    output logic [FW-1:0] x2_o,
    output logic [FW-1:0] z2_o
);
    localparam logic [FW-1:0] ONE = FW'(1);

    logic          busy, load, advance, capture, bit_now, last;
    step_op_e      op;
    logic [FW-1:0] xp_sq, xp_sq2;
    logic [FW-1:0] xp_q, x1_q, z1_q, x2_q, z2_q, x3_q, z3_q;

    gf_square #(.FW(FW), .POLY(POLY)) u_sq1 (.a(xp_i),  .y(xp_sq));
    gf_square #(.FW(FW), .POLY(POLY)) u_sq2 (.a(xp_sq), .y(xp_sq2));

    key_walker #(.FW(FW)) u_walk (
        .clk(clk), .rst(rst), .load(load), .advance(advance),
        .key(key_i), .bit_now(bit_now), .last(last)
    );

    ladder_fsm u_fsm (
        .clk(clk), .rst(rst), .start(start_i), .dp_done(dp_done_i),
        .bit_now(bit_now), .last(last), .busy(busy), .dp_start(dp_start_o),
        .op(op), .load(load), .advance(advance), .capture(capture),
        .done(done_o)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            xp_q <= '0; x1_q <= '0; z1_q <= '0;
            x2_q <= '0; z2_q <= '0; x3_q <= '0; z3_q <= '0;
        end else if (load) begin
            xp_q <= xp_i;
            x2_q <= xp_i;
            z2_q <= ONE;
            x1_q <= key_i[0] ? xp_i : '0;
            z1_q <= key_i[0] ? ONE : '0;
            x3_q <= xp_sq2 ^ b_i;
            z3_q <= xp_sq;
        end else if (capture) begin
            if (op == OP_DOUBLE) begin
                x2_q <= dp_rx_i;
                z2_q <= dp_rz_i;
            end else begin
                x1_q <= dp_rx_i;
                z1_q <= dp_rz_i;
            end
        end
    end

    assign dp_op_o = op;
    assign dp_xp_o = xp_q;
    assign dp_xa_o = (op == OP_ADJUST) ? x3_q : x1_q;
    assign dp_za_o = (op == OP_ADJUST) ? z3_q : z1_q;
    assign dp_xb_o = x2_q;
    assign dp_zb_o = z2_q;
    assign x1_o    = x1_q;
    assign z1_o    = z1_q;
    assign x2_o    = x2_q;
    assign z2_o    = z2_q;
endmodule

// File: rtl/ecc_ladder_seq_chk.sv
module ecc_ladder_seq_chk #(
    parameter int unsigned FW = 163
) (
    input logic            clk,
    input logic            rst,
    input logic            busy,
    input logic            start_i,
    input logic            dp_start,
    input logic [1:0]      dp_op,
    input logic            dp_done,
    input logic            done,
    input logic [4*FW-1:0] res
);
    assert_start_single_R7: assert property (@(posedge clk) disable iff (rst)
        dp_start |=> !dp_start);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    assert_done_after_adjust_R6: assert property (@(posedge clk) disable iff (rst)
        done |-> ($past(dp_done) && $past(dp_op) == 2'd2));

    assert_hold_idle_R9: assert property (@(posedge clk) disable iff (rst)
        (!busy && !start_i) |=> $stable(res));

    assert_ignore_busy_R8: assert property (@(posedge clk) disable iff (rst)
        (busy && start_i && !dp_done) |=> $stable(res));

    assert_reset_quiet_R10: assert property (@(posedge clk)
        rst |=> (!done && !dp_start));
endmodule

bind ecc_ladder_seq ecc_ladder_seq_chk #(.FW(FW)) u_chk (
    .clk(clk), .rst(rst), .busy(busy), .start_i(start_i),
    .dp_start(dp_start_o), .dp_op(dp_op_o), .dp_done(dp_done_i),
    .done(done_o), .res({x1_o, z1_o, x2_o, z2_o})
);

// File: tb/ecc_ladder_seq_test.sv
module ecc_ladder_seq_test;
    localparam int W = 163;
    localparam int CLK_PERIOD = 10;
    localparam logic [W-1:0] POLY = W'('hC9);

    logic clk = 1'b0, rst = 1'b1, start_i = 1'b0;
    logic [W-1:0] key_i = '0, xp_i = '0, b_i = '0;
    logic dp_start_o, dp_done_i = 1'b0, done_o;
    logic [1:0] dp_op_o;
    logic [W-1:0] dp_xp_o, dp_xa_o, dp_za_o, dp_xb_o, dp_zb_o;
    logic [W-1:0] dp_rx_i = '0, dp_rz_i = '0;
    logic [W-1:0] x1_o, z1_o, x2_o, z2_o;

    ecc_ladder_seq uut (
        .clk(clk), .rst(rst), .start_i(start_i), .key_i(key_i), .xp_i(xp_i),
        .b_i(b_i), .dp_start_o(dp_start_o), .dp_op_o(dp_op_o),
        .dp_xp_o(dp_xp_o), .dp_xa_o(dp_xa_o), .dp_za_o(dp_za_o),
        .dp_xb_o(dp_xb_o), .dp_zb_o(dp_zb_o), .dp_done_i(dp_done_i),
        .dp_rx_i(dp_rx_i), .dp_rz_i(dp_rz_i), .done_o(done_o),
        .x1_o(x1_o), .z1_o(z1_o), .x2_o(x2_o), .z2_o(z2_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int checks = 0, fails = 0;

    task automatic check(input bit ok, input string req, input string what,
                         input logic [W-1:0] act, input logic [W-1:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [W-1:0] rotl(input logic [W-1:0] v, input int n);
        return (v << n) | (v >> (W - n));
    endfunction

    function automatic logic [W-1:0] gfmul(input logic [W-1:0] a, input logic [W-1:0] b);
        logic [W-1:0] r = '0;
        for (int i = W - 1; i >= 0; i--) begin
            logic c = r[W-1];
            r = r << 1;
            if (c) r = r ^ POLY;
            if (b[i]) r = r ^ a;
        end
        return r;
    endfunction

    // Datapath stand-in: deterministic mixing so the operation order shows in the results.
    function automatic logic [W-1:0] mix_x(input logic [1:0] op, input logic [W-1:0] xa,
        input logic [W-1:0] za, input logic [W-1:0] xb, input logic [W-1:0] zb);
        if (op == 2'd0) return rotl(xb, 3) ^ zb;
        return xa ^ rotl(zb, 1) ^ rotl(xb, 2) ^ rotl(za, 4);
    endfunction

    function automatic logic [W-1:0] mix_z(input logic [1:0] op, input logic [W-1:0] xa,
        input logic [W-1:0] za, input logic [W-1:0] xb, input logic [W-1:0] zb);
        if (op == 2'd0) return xb ^ rotl(zb, 5) ^ W'(7);
        return za ^ xb ^ rotl(zb, 7) ^ rotl(xa, 9) ^ W'(1);
    endfunction

    int lat = 0, cyc = 0, n_dbl = 0, n_add = 0, n_adj = 0, proto_err = 0, adj_cyc = 0;
    bit pend = 0, seen_add = 0, seen_dbl = 0;
    int cd = 0;
    logic [1:0] c_op;
    logic [W-1:0] c_xa, c_za, c_xb, c_zb;
    logic [W-1:0] f_dbl_xb, f_dbl_zb, f_add_xa, f_add_za, adj_xa, adj_za;

    always @(negedge clk) begin
        cyc++;
        dp_done_i = 1'b0;
        if (pend) begin
            if (cd == 0) begin
                dp_done_i = 1'b1;
                dp_rx_i = mix_x(c_op, c_xa, c_za, c_xb, c_zb);
                dp_rz_i = mix_z(c_op, c_xa, c_za, c_xb, c_zb);
                pend = 0;
                if (c_op == 2'd2) adj_cyc = cyc;
            end else cd--;
        end
        if (dp_start_o) begin
            if (pend) proto_err++;
            pend = 1; cd = lat;
            c_op = dp_op_o; c_xa = dp_xa_o; c_za = dp_za_o; c_xb = dp_xb_o; c_zb = dp_zb_o;
            case (dp_op_o)
                2'd0: begin
                    n_dbl++;
                    if (!seen_dbl) begin seen_dbl = 1; f_dbl_xb = dp_xb_o; f_dbl_zb = dp_zb_o; end
                end
                2'd1: begin
                    n_add++;
                    if (!seen_add) begin seen_add = 1; f_add_xa = dp_xa_o; f_add_za = dp_za_o; end
                end
                2'd2: begin n_adj++; adj_xa = dp_xa_o; adj_za = dp_za_o; end
                default: proto_err++;
            endcase
        end
    end

    task automatic do_reset();
        rst = 1'b1;
        repeat (3) @(negedge clk);
        #1;
        check(done_o == 1'b0 && dp_start_o == 1'b0, "R10", "done/start in reset",
              W'({done_o, dp_start_o}), '0);
        check((x1_o | z1_o | x2_o | z2_o) == '0, "R10", "results in reset",
              x1_o | z1_o | x2_o | z2_o, '0);
        @(negedge clk); #1;
        rst = 1'b0;
    endtask

    task automatic run(input string name, input logic [W-1:0] k, input logic [W-1:0] xp,
                       input logic [W-1:0] b, input int latency, input bit poke);
        logic [W-1:0] x1, z1, x2, z2, x3, z3, sq;
        int ones = 0, t = 0, done_at = -1;
        bit hung = 0;
        lat = latency; n_dbl = 0; n_add = 0; n_adj = 0; proto_err = 0;
        seen_add = 0; seen_dbl = 0;
        // expected replay
        sq = gfmul(xp, xp);
        x3 = gfmul(sq, sq) ^ b; z3 = sq;
        x2 = xp; z2 = W'(1);
        x1 = k[0] ? xp : '0; z1 = k[0] ? W'(1) : '0;
        for (int i = 1; i < W; i++) begin
            logic [W-1:0] nx = mix_x(2'd0, x1, z1, x2, z2);
            logic [W-1:0] nz = mix_z(2'd0, x1, z1, x2, z2);
            x2 = nx; z2 = nz;
            if (k[i]) begin
                ones++;
                nx = mix_x(2'd1, x1, z1, x2, z2);
                nz = mix_z(2'd1, x1, z1, x2, z2);
                x1 = nx; z1 = nz;
            end
        end
        begin
            logic [W-1:0] ax = mix_x(2'd2, x3, z3, x2, z2);
            logic [W-1:0] az = mix_z(2'd2, x3, z3, x2, z2);
            x1 = ax; z1 = az;
        end
        // stimulus
        key_i = k; xp_i = xp; b_i = b; start_i = 1'b1;
        @(negedge clk); #1;
        start_i = 1'b0;
        while (done_at < 0) begin
            @(negedge clk); #1;
            t++;
            if (poke && t == 50) begin start_i = 1'b1; key_i = ~k; xp_i = ~xp; b_i = ~b; end
            if (poke && t == 51) begin start_i = 1'b0; key_i = k; xp_i = xp; b_i = b; end
            if (done_o) done_at = cyc;
            if (t > 20000) begin hung = 1; break; end
        end
        check(!hung, "R9", {name, " done seen"}, W'(t), '0);
        check(done_at == adj_cyc + 1, "R9", {name, " done one cycle after adjust"},
              W'(done_at), W'(adj_cyc + 1));
        @(negedge clk); #1;
        check(done_o == 1'b0, "R9", {name, " done single cycle"}, W'(done_o), '0);
        check(n_dbl == W - 1, "R4", {name, " doubling count"}, W'(n_dbl), W'(W - 1));
        check(n_add == ones, "R5", {name, " addition count"}, W'(n_add), W'(ones));
        check(n_adj == 1, "R6", {name, " adjustment count"}, W'(n_adj), W'(1));
        check(proto_err == 0, "R7", {name, " request overlap or bad code"}, W'(proto_err), '0);
        check(f_dbl_xb == xp && f_dbl_zb == W'(1), "R1", {name, " first doubling operands"},
              f_dbl_xb, xp);
        if (ones > 0)
            check(f_add_xa == (k[0] ? xp : '0) && f_add_za == (k[0] ? W'(1) : '0), "R3",
                  {name, " initial accumulator"}, f_add_xa, k[0] ? xp : '0);
        check(adj_xa == x3, "R2", {name, " correction x"}, adj_xa, x3);
        check(adj_za == z3, "R2", {name, " correction z"}, adj_za, z3);
        check(x1_o == x1 && z1_o == z1, "R6", {name, " final accumulator"}, x1_o, x1);
        check(x2_o == x2 && z2_o == z2, "R5", {name, " final doubled point"}, x2_o, x2);
        if (poke)
            check(x1_o == x1 && x2_o == x2 && n_dbl == W - 1, "R8",
                  {name, " mid-run start ignored"}, x1_o, x1);
        repeat (8) @(negedge clk);
        #1;
        check(x1_o == x1 && z1_o == z1 && x2_o == x2 && z2_o == z2, "R9",
              {name, " results held after done"}, x2_o, x2);
    endtask

    initial begin
        #(CLK_PERIOD * 150000);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        logic [W-1:0] xp_a, b_a, key_a;
        xp_a  = W'({6{32'h9E3779B9}});
        b_a   = W'({6{32'h2545F491}});
        key_a = W'({41{4'b1011}});
        do_reset();
        run("mixed_k0one",  key_a,                      xp_a,  b_a,  0, 0);
        run("k0zero",       key_a & ~W'(1),             ~xp_a, b_a,  2, 0);
        run("only_lsb",     W'(1),                      xp_a,  ~b_a, 1, 0);
        run("all_ones",     '1,                         rotl(xp_a, 11), b_a, 0, 0);
        run("top_bit_only", W'(1) << (W - 1),           xp_a,  b_a,  3, 0);
        run("busy_start",   W'({11{16'hC3A5}}),         xp_a ^ b_a, b_a, 1, 1);
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule